// File: doc/BRIEF.md
# Banked External Interrupt Aggregator

This block collects up to 128 peripheral interrupt lines, grouped into banks of 32, and funnels them onto a small set of CPU trigger outputs. Every line passes through a synchroniser. It is then captured as edge- or level-sensitive, according to its sense bit, into a per-bank pending status word. A line that is pending and enabled by its mask bit drives the trigger output chosen by its own routing register.

Software reaches all state through a simple single-cycle register bus. Each bank has a pending word, a sense word and an enable word. Each source has a routing register. Software writes a 1 to a pending bit to clear an edge interrupt, or to fire it again. For a level interrupt, the same write raises it again for one cycle. A source number splits into a bank index (number >> 5) and a bit position (number & 31).

Top module: `irq_bank_aggregator`

## Requirements
- R1: After reset all pending, sense, enable and routing state is 0, `trig_o` is 0 and every register reads 0.
- R2: An edge source (sense bit 0) sets its pending bit on a rising edge of its input, seen two cycles after the input changes. The bit stays set after the input falls.
- R3: A level source (sense bit 1) has a pending bit that follows its synchronised input: set while the input is high, cleared after it falls.
- R4: For an edge source, writing 1 to its pending bit inverts the bit and writing 0 leaves it unchanged. A 0-to-1 change made by such a write drives the routed trigger again.
- R5: For a level source whose input is low, writing 1 to its pending bit makes it read as pending for exactly one cycle.
- R6: An enable bit of 0 keeps its source off every trigger, while the pending bit stays readable.
- R7: A routing value of 0 detaches the source. A value v in 1..NTRIG drives `trig_o[v-1]`. A larger value drives no output. A routing register keeps only the low clog2(NTRIG+1) bits of a write.
- R8: `trig_o[t]` is registered. In each cycle it equals the OR, over all sources, of pending AND enabled AND routing == t+1, taken from the previous cycle.
- R9: Address map (byte addresses, bank b, bit o):
  - pending words are at 0x000+8b, sense words at 0x040+8b and enable words at 0x080+8b;
  - routing registers are at 0x1000·(b+1)+4o;
  - addresses that hit no register, and banks at or above NBANK, read 0 and ignore writes.
- R10: Read data appears on `bus_rdata` in the cycle after a read request and is 0 in any cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32·NBANK | Peripheral interrupt lines, asynchronous |
| bus_req | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| trig_o | output | NTRIG | Active-high CPU trigger outputs |

## Verification
The assertions check these properties on every cycle:
- triggers stay quiet after reset and while every enable bit is 0;
- a trigger is high only when some source was pending and enabled;
- edge pending bits never clear without a software write;
- level pending bits track the synchronised input;
- read data is zero when no read preceded it.

The routing of a source to one particular output needs the bench's scenarios, as do the toggle and re-fire effect of status writes, the one-cycle level re-raise and the decoding of the address map. The bench's reference model compares both outputs on every clock during directed and random traffic.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int BANK_W = 32;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      GRP_STAT  = 2'd0,
      GRP_SENSE = 2'd1,
      GRP_MASK  = 2'd2,
      GRP_NONE  = 2'd3
   } reg_grp_e;

   typedef struct packed {
      logic       hit_reg;
      logic       hit_vec;
      reg_grp_e   grp;
      logic [2:0] bank;
      logic [4:0] offs;
   } dec_t;

   // bank words: 8-byte stride inside a 64-byte group; routing: 4 KiB block per bank
   function automatic dec_t decode(input logic [ADDR_W-1:0] a, input int nbank);
      dec_t d;
      d      = '0;
      d.grp  = reg_grp_e'(a[7:6]);
      d.offs = a[6:2];
      if (a[15:12] == 4'd0) begin
         d.bank    = a[5:3];
         d.hit_reg = (a[2:0] == 3'd0) && (a[11:8] == 4'd0) &&
                     (d.grp != GRP_NONE) && (int'(a[5:3]) < nbank);
      end else begin
         d.bank    = 3'(a[15:12] - 4'd1);
         d.hit_vec = (a[11:7] == 5'd0) && (a[1:0] == 2'd0) &&
                     (int'(a[15:12]) <= nbank);
      end
      return d;
   endfunction
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("irq_agg_sync: DEPTH must be at least 2");
   end

   logic [W-1:0] stg [DEPTH+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k <= DEPTH; k++) stg[k] <= '0;
      end else begin
         stg[0] <= din;
         for (int k = 1; k <= DEPTH; k++) stg[k] <= stg[k-1];
      end
   end

   assign lvl  = stg[DEPTH-1];
   assign rise = stg[DEPTH-1] & ~stg[DEPTH];
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
   import irq_agg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] lvl,
   input  logic [BANK_W-1:0] rise,
   input  logic              wr_stat,
   input  logic              wr_sense,
   input  logic              wr_mask,
   input  logic [DATA_W-1:0] wdata,
   output logic [BANK_W-1:0] stat,
   output logic [BANK_W-1:0] sense,
   output logic [BANK_W-1:0] mask
);
   logic [BANK_W-1:0] stat_q, sense_q, mask_q, stat_d, tog;

   always_comb begin
      tog    = wr_stat ? wdata[BANK_W-1:0] : '0;
      stat_d = (sense_q & (lvl | tog)) | (~sense_q & ((stat_q ^ tog) | rise));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         sense_q <= '0;
         mask_q  <= '0;
      end else begin
         stat_q <= stat_d;
         if (wr_sense) sense_q <= wdata[BANK_W-1:0];
         if (wr_mask)  mask_q  <= wdata[BANK_W-1:0];
      end
   end

   assign stat  = stat_q;
   assign sense = sense_q;
   assign mask  = mask_q;
endmodule

// File: rtl/irq_agg_route.sv
module irq_agg_route #(
   parameter int NSRC  = 128,
   parameter int NTRIG = 4,
   parameter int VEC_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC-1:0]       pend,
   input  logic [NSRC*VEC_W-1:0] vec,
   output logic [NTRIG-1:0]      trig
);
   for (genvar t = 0; t < NTRIG; t++) begin : g_trig
      logic [NSRC-1:0] hit;
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         assign hit[s] = pend[s] && (vec[s*VEC_W +: VEC_W] == VEC_W'(t + 1));
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trig[t] <= 1'b0;
         else        trig[t] <= |hit;
      end
   end
endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NBANK      = 4,
   parameter int NTRIG      = 4,
   parameter int SYNC_DEPTH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NBANK*BANK_W-1:0] irq_i,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [NTRIG-1:0]        trig_o
);
   localparam int NSRC  = NBANK * BANK_W;
   localparam int VEC_W = $clog2(NTRIG + 1);

   if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
      $error("irq_bank_aggregator: NBANK must be 1..4");
   end
   if (NTRIG < 1 || NTRIG > 15) begin : g_bad_ntrig
      $error("irq_bank_aggregator: NTRIG must be 1..15");
   end

   dec_t dec;
   logic wr_any, wr_vec;
   int   vsel;

   assign dec    = decode(bus_addr, NBANK);
   assign wr_any = bus_req && bus_we;
   assign wr_vec = wr_any && dec.hit_vec;
   assign vsel   = int'(dec.bank) * BANK_W + int'(dec.offs);

   // synchroniser and edge detect
   logic [NSRC-1:0] sync_all, rise_all;
   irq_agg_sync #(.W(NSRC), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(irq_i), .lvl(sync_all), .rise(rise_all)
   );

   // per-bank capture state
   logic [NSRC-1:0]   stat_all, sense_all, mask_all;
   logic [NBANK-1:0]  wr_stat_b;
   logic              stat_wr;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel;
      assign sel          = wr_any && dec.hit_reg && (dec.bank == 3'(b));
      assign wr_stat_b[b] = sel && (dec.grp == GRP_STAT);
      irq_agg_bank u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl     (sync_all[b*BANK_W +: BANK_W]),
         .rise    (rise_all[b*BANK_W +: BANK_W]),
         .wr_stat (wr_stat_b[b]),
         .wr_sense(sel && (dec.grp == GRP_SENSE)),
         .wr_mask (sel && (dec.grp == GRP_MASK)),
         .wdata   (bus_wdata),
         .stat    (stat_all[b*BANK_W +: BANK_W]),
         .sense   (sense_all[b*BANK_W +: BANK_W]),
         .mask    (mask_all[b*BANK_W +: BANK_W])
      );
   end
   assign stat_wr = |wr_stat_b;

   // per-source routing registers
   logic [VEC_W-1:0]      vec_q [NSRC];
   logic [NSRC*VEC_W-1:0] vec_flat;

   for (genvar s = 0; s < NSRC; s++) begin : g_vec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   vec_q[s] <= '0;
         else if (wr_vec && vsel == s) vec_q[s] <= bus_wdata[VEC_W-1:0];
      end
      assign vec_flat[s*VEC_W +: VEC_W] = vec_q[s];
   end

   irq_agg_route #(.NSRC(NSRC), .NTRIG(NTRIG), .VEC_W(VEC_W)) u_route (
      .clk(clk), .rst_n(rst_n), .pend(stat_all & mask_all), .vec(vec_flat), .trig(trig_o)
   );

   // read path
   logic [DATA_W-1:0] rd_d;
   always_comb begin
      rd_d = '0;
      if (dec.hit_reg) begin
         for (int b = 0; b < NBANK; b++) begin
            if (dec.bank == 3'(b)) begin
               case (dec.grp)
                  GRP_STAT:  rd_d = stat_all[b*BANK_W +: BANK_W];
                  GRP_SENSE: rd_d = sense_all[b*BANK_W +: BANK_W];
                  GRP_MASK:  rd_d = mask_all[b*BANK_W +: BANK_W];
                  default:   rd_d = '0;
               endcase
            end
         end
      end else if (dec.hit_vec) begin
         for (int s = 0; s < NSRC; s++) begin
            if (vsel == s) rd_d = {{(DATA_W-VEC_W){1'b0}}, vec_q[s]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= (bus_req && !bus_we) ? rd_d : '0;
   end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
   parameter int NSRC  = 128,
   parameter int NTRIG = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_req,
   input logic             bus_we,
   input logic [31:0]      bus_rdata,
   input logic [NTRIG-1:0] trig_o,
   input logic [NSRC-1:0]  stat_all,
   input logic [NSRC-1:0]  sense_all,
   input logic [NSRC-1:0]  mask_all,
   input logic [NSRC-1:0]  sync_all,
   input logic             stat_wr
);
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (trig_o == '0));

   p_edge_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stat_wr) |-> (($past(stat_all) & ~$past(sense_all) & ~stat_all) == '0));

   p_level_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stat_wr) |-> (((stat_all ^ $past(sync_all)) & $past(sense_all)) == '0));

   p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask_all) == '0) |-> (trig_o == '0));

   p_trig_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o != '0) |-> ($past(stat_all & mask_all) != '0));

   p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_req && !bus_we) |-> (bus_rdata == '0));
endmodule

bind irq_bank_aggregator irq_agg_chk #(.NSRC(NSRC), .NTRIG(NTRIG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_rdata(bus_rdata),
   .trig_o   (trig_o),
   .stat_all (stat_all),
   .sense_all(sense_all),
   .mask_all (mask_all),
   .sync_all (sync_all),
   .stat_wr  (stat_wr)
);

// File: tb/tb_irq_bank_aggregator.sv
module tb_irq_bank_aggregator;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int NT = 4;
   localparam int NS = NB * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq = '0;
   logic          req = 1'b0, we = 1'b0;
   logic [15:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NT-1:0] trig;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_bank_aggregator #(.NBANK(NB), .NTRIG(NT)) dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_req(req), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .trig_o(trig)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   bit [NS-1:0] m_s1, m_s2, m_s3, m_stat, m_sense, m_mask, nstat;
   int          m_vec [NS];
   bit [NT-1:0] m_trig, ntrig;
   bit [31:0]   m_rd, nrd;
   int          mk, mb, mi;

   // kind: 0 none, 1 pending, 2 sense, 3 enable, 4 routing
   function automatic void m_decode(input int a, output int kind, output int bank, output int idx);
      kind = 0; bank = 0; idx = 0;
      if (a < 'hC0) begin
         if (a % 8 == 0 && (a % 64) / 8 < NB) begin
            kind = a / 64 + 1;
            bank = (a % 64) / 8;
         end
      end else if (a >= 'h1000 && a < 'h1000 * (NB + 1) && (a % 'h1000) < 128 && a % 4 == 0) begin
         kind = 4;
         bank = a / 'h1000 - 1;
         idx  = bank * 32 + (a % 'h1000) / 4;
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_s3 = '0; m_stat = '0; m_sense = '0; m_mask = '0;
         for (int i = 0; i < NS; i++) m_vec[i] = 0;
         m_trig = '0; m_rd = '0;
      end else begin
         m_decode(int'(addr), mk, mb, mi);
         nrd = '0;
         if (req && !we) begin
            case (mk)
               1: nrd = m_stat[mb*32 +: 32];
               2: nrd = m_sense[mb*32 +: 32];
               3: nrd = m_mask[mb*32 +: 32];
               4: nrd = 32'(m_vec[mi]);
               default: nrd = '0;
            endcase
         end
         for (int t = 0; t < NT; t++) begin
            ntrig[t] = 1'b0;
            for (int i = 0; i < NS; i++)
               if (m_stat[i] && m_mask[i] && m_vec[i] == t + 1) ntrig[t] = 1'b1;
         end
         for (int i = 0; i < NS; i++) begin
            bit tg;
            tg = req && we && mk == 1 && mb == i / 32 && wdata[i % 32];
            if (m_sense[i]) nstat[i] = m_s2[i] | tg;
            else            nstat[i] = (m_stat[i] ^ tg) | (m_s2[i] & ~m_s3[i]);
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq;
         m_stat = nstat; m_trig = ntrig; m_rd = nrd;
         if (req && we) begin
            if (mk == 2) m_sense[mb*32 +: 32] = wdata;
            if (mk == 3) m_mask[mb*32 +: 32] = wdata;
            if (mk == 4) m_vec[mi] = int'(wdata & 32'h7);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 trigger vs model", 32'(trig), 32'(m_trig));
         chk("R10 read data vs model", rdata, m_rd);
      end
   end

   // ---------------- bus tasks (enter and leave at a falling edge) ----------------
   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
      req = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      req = 1'b0;
      chk(tag, rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(16'h0000, 32'h0, "R1 pending bank0");
      rd(16'h0058, 32'h0, "R1 sense bank3");
      rd(16'h0098, 32'h0, "R1 enable bank3");
      rd(16'h407C, 32'h0, "R1 routing src127");
      chk("R1 trig", 32'(trig), 32'h0);

      // R9 address map and readback
      wr(16'h0050, 32'hA5A5_0000);
      rd(16'h0050, 32'hA5A5_0000, "R9 sense bank2 readback");
      wr(16'h0088, 32'h1234_5678);
      rd(16'h0088, 32'h1234_5678, "R9 enable bank1 readback");
      wr(16'h2014, 32'h3);
      rd(16'h2014, 32'h3, "R9 routing src37 readback");
      wr(16'h2014, 32'hFF);
      rd(16'h2014, 32'h7, "R7 routing keeps low bits");
      wr(16'h2014, 32'h0);
      rd(16'h00C0, 32'h0, "R9 unmapped group");
      wr(16'h0004, 32'hFFFF_FFFF);
      rd(16'h0004, 32'h0, "R9 misaligned");
      rd(16'h0020, 32'h0, "R9 bank beyond NBANK");
      rd(16'h5000, 32'h0, "R9 routing beyond NBANK");
      wr(16'h0088, 32'h0);
      wr(16'h0050, 32'h0);

      // R2 edge capture on src3 routed to trigger 2
      wr(16'h0080, 32'h8);
      wr(16'h1000 + 16'd12, 32'h2);
      irq[3] = 1'b1;
      idle(5);
      rd(16'h0000, 32'h8, "R2 edge pending set");
      chk("R2 trigger 2 driven", 32'(trig), 32'h2);
      irq[3] = 1'b0;
      idle(5);
      rd(16'h0000, 32'h8, "R2 edge pending held after input falls");

      // R4 toggle and re-fire
      wr(16'h0000, 32'h8);
      rd(16'h0000, 32'h0, "R4 write 1 clears");
      idle(1);
      chk("R4 trigger dropped", 32'(trig), 32'h0);
      wr(16'h0000, 32'h0);
      rd(16'h0000, 32'h0, "R4 write 0 no effect");
      wr(16'h0000, 32'h8);
      rd(16'h0000, 32'h8, "R4 write 1 re-raises");
      chk("R4 trigger re-fires", 32'(trig), 32'h2);

      // R6 enable off hides from trigger but not from status
      wr(16'h0080, 32'h0);
      idle(2);
      chk("R6 masked trigger quiet", 32'(trig), 32'h0);
      rd(16'h0000, 32'h8, "R6 pending still visible");
      wr(16'h0000, 32'h8);

      // R7 routing of src40 (bank1 bit8)
      wr(16'h0088, 32'h100);
      irq[40] = 1'b1;
      idle(5);
      irq[40] = 1'b0;
      rd(16'h0008, 32'h100, "R7 src40 pending");
      chk("R7 routing 0 detached", 32'(trig), 32'h0);
      wr(16'h2020, 32'h4);
      idle(1);
      chk("R7 routing 4 drives trig[3]", 32'(trig), 32'h8);
      wr(16'h2020, 32'h6);
      idle(1);
      chk("R7 routing 6 drives none", 32'(trig), 32'h0);
      wr(16'h2020, 32'h1);
      idle(1);
      chk("R7 routing 1 drives trig[0]", 32'(trig), 32'h1);
      wr(16'h0008, 32'h100);
      idle(2);

      // R3 level source src64 routed to trigger 3
      wr(16'h0050, 32'h1);
      wr(16'h0090, 32'h1);
      wr(16'h3000, 32'h3);
      irq[64] = 1'b1;
      idle(5);
      rd(16'h0010, 32'h1, "R3 level pending while high");
      chk("R3 trigger 3 driven", 32'(trig), 32'h4);
      irq[64] = 1'b0;
      idle(5);
      rd(16'h0010, 32'h0, "R3 level pending cleared");
      chk("R3 trigger released", 32'(trig), 32'h0);

      // R5 level re-raise pulse
      wr(16'h0010, 32'h1);
      rd(16'h0010, 32'h1, "R5 raised for one cycle");
      rd(16'h0010, 32'h0, "R5 back to input level");

      // R8 random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         int r, b;
         r = int'($urandom % 6);
         b = int'($urandom % NB);
         if ($urandom % 4 == 0) irq[$urandom % NS] = ~irq[$urandom % NS];
         if ($urandom % 3 == 0) begin
            int s;
            s = int'($urandom % NS);
            irq[s] = ~irq[s];
         end
         case (r)
            0: wr(16'(8 * b), $urandom);
            1: wr(16'(16'h40 + 8 * b), $urandom);
            2: wr(16'(16'h80 + 8 * b), $urandom);
            3: wr(16'(16'h1000 * (b + 1) + 4 * ($urandom % 32)), $urandom % 8);
            4: begin
               req = 1'b1; we = 1'b0; addr = 16'(8 * b);
               @(negedge clk);
               req = 1'b0;
            end
            default: idle(1);
         endcase
      end
      idle(4);
      finish_run();
   end
endmodule